// File: doc/BRIEF.md
# NFC Multi-Rate Frame Encoder

This block turns a serial stream of data bits into a framed baseband waveform for a short-range contactless peer-to-peer link. One clock cycle equals one cycle of the RF carrier. A frame has a start field, the data bits and an end field. The waveform comes out on a single line that is high when the link is unmodulated.

The coding is picked from three settings: the bit rate, the role (target or initiator) and the mode (active or passive). At the lowest rate, an active device or an initiator uses pause coding whose pattern depends on the previous bit. Every other combination uses Manchester coding. A passive target also chops the modulated half-bits with a subcarrier, so the output can drive a load-modulation switch directly.

The data source presents a bit on `dataIn`. It moves to the next bit after it has seen `bitAck`. It raises `frameStop` when it has no more bits to send.

Top module: `nfc_frame_encoder`

## Requirements
- R1: After reset, and whenever no frame is in progress, `codedOut` is high and `bitAck` is low.
- R2: A frame starts on a clock edge where `frameStart` is high and no frame is in progress. `rateSel`, `initiatorRole` and `activeMode` are captured at that edge. While a frame is in progress, changes on those three inputs and on `frameStart` have no effect on the frame.
- R3: One bit period lasts 128 clock cycles for rate code 00, 64 for 01 and 32 for 10. Rate code 11 behaves like 10.
- R4: `bitAck` is high for the last cycle of the start field and the last cycle of each data bit, provided `frameStop` is low in that cycle. `dataIn` is taken at the closing edge of that cycle and is sent in the next bit period.
- R5: If `frameStop` is high in the last cycle of the start field or of a data bit, the end field follows next and no bit is taken.
- R6: Pause coding is used when the rate code is 00 and either `activeMode`=1 or `initiatorRole`=1. Manchester coding is used for all other settings.
- R7: In pause coding, a data 1 drives `codedOut` low for cycles [P/2, 3P/4) of its bit period, where P is the bit period. It is high for the rest of the period.
- R8: In pause coding, the start field is low for cycles [0, P/4). A data 0 that follows a 0 or the start field has the same pattern. A data 0 that follows a 1 stays high for the whole period.
- R9: The pause-coded end field has two parts. The first is a data-0 pattern that follows the R8 rule for the previous bit, using 0 after an empty frame. The second is one fully high bit period. The block then returns to idle.
- R10: In Manchester coding, the start field is coded as a 1. A 1 is modulated in the first half of its period and a 0 in the second half. The end field is one unmodulated bit period. For an active device or an initiator, a modulated half is low and an unmodulated half is high.
- R11: For a passive target (`activeMode`=0 and `initiatorRole`=0), a modulated half carries a subcarrier with a period of 16, 8 or 4 cycles for rate codes 00, 01 and 10. The subcarrier is high for the first half of each of its periods, counted from the start of the bit. Unmodulated halves are high.
- R12: `bitAck` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier-rate clock |
| rstN | input | 1 | Asynchronous reset, active low |
| activeMode | input | 1 | 1 = active, 0 = passive |
| rateSel | input | 2 | Bit-rate code (00, 01, 10; 11 is treated as 10) |
| initiatorRole | input | 1 | 1 = initiator, 0 = target |
| frameStart | input | 1 | Request to start a frame |
| frameStop | input | 1 | High when no further data bit is offered |
| dataIn | input | 1 | Data bit offered for the next bit period |
| bitAck | output | 1 | Pulse: the offered bit is taken at this cycle's closing edge |
| codedOut | output | 1 | Coded baseband output, high = unmodulated |

## Verification
The hardest case to reach from the ports is a frame whose settings are changed while it is running. In that case a second start request must be ignored, and the waveform must keep the coding and timing captured at the start. The stimulus handles this in three steps. It queues the complete expected waveform as soon as the frame begins. It then flips all three settings and pulses `frameStart` in the middle of the frame. Finally it compares every output cycle against the queued waveform.

Two other cases also need deliberate bit sequences. One is the pause-coded zero that follows a one. The other is the end field of an empty frame. For these, the bench chooses frames with 1-to-0 transitions and a frame with no data bits.

// File: rtl/nfc_enc_pkg.sv
package nfc_enc_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_SOF, PH_CODE, PH_EOF} phase_t;

  typedef struct packed {
    logic [1:0] rateSel;
    logic       initiator;
    logic       active;
  } cfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic startFrame;
    logic advance;
    logic takeBit;
    logic fromSof;
  } strobe_t;
endpackage

// File: rtl/nfc_enc_ctrl.sv
module nfc_enc_ctrl
  import nfc_enc_pkg::*;
#(
  parameter int BIT_LEN_BASE = 128,
  localparam int CW = $clog2(BIT_LEN_BASE)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          frameStart,
  input  logic          frameStop,
  input  cfg_t          cfgIn,
  output phase_t        phase,
  output logic [CW-1:0] cnt,
  output logic          eofTail,
  output cfg_t          cfg,
  output logic          useMiller,
  output strobe_t       strobe,
  output logic          bitAck
);
  logic [CW-1:0] lastCnt;
  logic          bitLast;
  cfg_t          cfgLatch;

  assign lastCnt   = CW'((BIT_LEN_BASE >> cfg.rateSel) - 1);
  assign bitLast   = (cnt == lastCnt);
  assign useMiller = (cfg.rateSel == 2'b00) && (cfg.active || cfg.initiator);

  always_comb begin
    cfgLatch = cfgIn;
    if (cfgIn.rateSel == 2'b11) cfgLatch.rateSel = 2'b10;
  end

  always_comb begin
    strobe.startFrame = (phase == PH_IDLE) && frameStart;
    strobe.fromSof    = (phase == PH_SOF);
    strobe.advance    = bitLast && ((phase == PH_SOF) || (phase == PH_CODE));
    strobe.takeBit    = strobe.advance && !frameStop;
  end

  assign bitAck = strobe.takeBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      eofTail <= 1'b0;
      cfg     <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          cnt     <= '0;
          eofTail <= 1'b0;
          if (frameStart) begin
            cfg   <= cfgLatch;
            phase <= PH_SOF;
          end
        end
        PH_SOF, PH_CODE: begin
          cnt <= bitLast ? '0 : cnt + 1'b1;
          if (bitLast) phase <= frameStop ? PH_EOF : PH_CODE;
        end
        PH_EOF: begin
          cnt <= bitLast ? '0 : cnt + 1'b1;
          if (bitLast) begin
            if (useMiller && !eofTail) eofTail <= 1'b1;
            else                       phase   <= PH_IDLE;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nfc_enc_dpath.sv
module nfc_enc_dpath
  import nfc_enc_pkg::*;
#(
  parameter int BIT_LEN_BASE = 128,
  parameter int SUB_DIV_BASE = 16,
  localparam int CW = $clog2(BIT_LEN_BASE)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          dataIn,
  input  strobe_t       strobe,
  input  phase_t        phase,
  input  logic [CW-1:0] cnt,
  input  logic          eofTail,
  input  cfg_t          cfg,
  input  logic          useMiller,
  output logic          codedOut
);
  logic curBit, prevBit;
  logic passiveTgt, modHalf, subPhase, millerOut;
  int   c, bitLen, halfLen, qtrLen, subHalf;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curBit  <= 1'b0;
      prevBit <= 1'b0;
    end else if (strobe.startFrame) begin
      curBit  <= 1'b0;
      prevBit <= 1'b0;
    end else if (strobe.advance) begin
      prevBit <= strobe.fromSof ? 1'b0 : curBit;
      if (strobe.takeBit) curBit <= dataIn;
    end
  end

  assign passiveTgt = !cfg.active && !cfg.initiator;

  always_comb begin
    c        = int'(cnt);
    bitLen   = BIT_LEN_BASE >> cfg.rateSel;
    halfLen  = bitLen / 2;
    qtrLen   = bitLen / 4;
    subHalf  = (SUB_DIV_BASE / 2) >> cfg.rateSel;
    subPhase = ((c & subHalf) == 0);

    unique case (phase)
      PH_SOF:  millerOut = (c >= qtrLen);
      PH_CODE: millerOut = curBit ? !((c >= halfLen) && (c < halfLen + qtrLen))
                                  : (prevBit || (c >= qtrLen));
      PH_EOF:  millerOut = eofTail || prevBit || (c >= qtrLen);
      default: millerOut = 1'b1;
    endcase

    unique case (phase)
      PH_SOF:  modHalf = (c < halfLen);
      PH_CODE: modHalf = curBit ? (c < halfLen) : (c >= halfLen);
      default: modHalf = 1'b0;
    endcase

    if (phase == PH_IDLE)  codedOut = 1'b1;
    else if (useMiller)    codedOut = millerOut;
    else if (!modHalf)     codedOut = 1'b1;
    else                   codedOut = passiveTgt ? subPhase : 1'b0;
  end
endmodule

// File: rtl/nfc_frame_encoder.sv
module nfc_frame_encoder
  import nfc_enc_pkg::*;
#(
  parameter int BIT_LEN_BASE = 128,
  parameter int SUB_DIV_BASE = 16,
  localparam int CW = $clog2(BIT_LEN_BASE)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       activeMode,
  input  logic [1:0] rateSel,
  input  logic       initiatorRole,
  input  logic       frameStart,
  input  logic       frameStop,
  input  logic       dataIn,
  output logic       bitAck,
  output logic       codedOut
);
  cfg_t          cfgIn, cfg;
  phase_t        phase;
  logic [CW-1:0] cnt;
  logic          eofTail, useMiller;
  strobe_t       strobe;

  assign cfgIn = '{rateSel: rateSel, initiator: initiatorRole, active: activeMode};

  nfc_enc_ctrl #(.BIT_LEN_BASE(BIT_LEN_BASE)) uCtrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .frameStop(frameStop),
    .cfgIn(cfgIn), .phase(phase), .cnt(cnt), .eofTail(eofTail), .cfg(cfg),
    .useMiller(useMiller), .strobe(strobe), .bitAck(bitAck)
  );

  nfc_enc_dpath #(.BIT_LEN_BASE(BIT_LEN_BASE), .SUB_DIV_BASE(SUB_DIV_BASE)) uDpath (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .strobe(strobe), .phase(phase),
    .cnt(cnt), .eofTail(eofTail), .cfg(cfg), .useMiller(useMiller),
    .codedOut(codedOut)
  );
endmodule

// File: rtl/nfc_enc_chk.sv
module nfc_enc_chk
  import nfc_enc_pkg::*;
(
  input logic   clk,
  input logic   rstN,
  input logic   frameStart,
  input logic   bitAck,
  input logic   codedOut,
  input phase_t phase,
  input cfg_t   cfg
);
  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE) |-> (codedOut && !bitAck));

  // R12
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitAck |=> !bitAck);

  // R4
  ack_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitAck |-> ((phase == PH_SOF) || (phase == PH_CODE)));

  // R2
  start_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((phase == PH_IDLE) && frameStart) |=> (phase == PH_SOF));

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((phase != PH_IDLE) && ($past(phase) != PH_IDLE)) |-> $stable(cfg));
endmodule

bind nfc_frame_encoder nfc_enc_chk uChk (
  .clk(clk), .rstN(rstN), .frameStart(frameStart), .bitAck(bitAck),
  .codedOut(codedOut), .phase(phase), .cfg(cfg)
);

// File: tb/sim_nfc_frame_encoder.sv
module sim_nfc_frame_encoder;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic activeMode = 1'b0, initiatorRole = 1'b0, frameStart = 1'b0;
  logic frameStop = 1'b0, dataIn = 1'b0;
  logic [1:0] rateSel = 2'b00;
  logic bitAck, codedOut;

  int checks = 0, fails = 0;
  logic eO[$];
  logic eA[$];
  string eT[$];
  logic fbits[32];
  int nBits = 0, idx = 0;
  logic feedOn = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nfc_frame_encoder u0 (
    .clk(clk), .rstN(rstN), .activeMode(activeMode), .rateSel(rateSel),
    .initiatorRole(initiatorRole), .frameStart(frameStart), .frameStop(frameStop),
    .dataIn(dataIn), .bitAck(bitAck), .codedOut(codedOut)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // expected waveform, derived from R7..R11; kind: 0 start, 1 data, 2 end, 3 end tail
  function automatic logic model(input logic mil, input logic pas, input int re,
                                 input int kind, input logic b, input logic p, input int c);
    int bl = 128 >> re;
    int h = bl / 2;
    int q = bl / 4;
    logic md;
    if (mil) begin
      case (kind)
        0: return c >= q;
        1: return b ? !(c >= h && c < h + q) : (p ? 1'b1 : (c >= q));
        2: return p ? 1'b1 : (c >= q);
        default: return 1'b1;
      endcase
    end
    md = (kind == 0) ? (c < h) : (kind == 1) ? (b ? (c < h) : (c >= h)) : 1'b0;
    if (!md) return 1'b1;
    return pas ? (((c / (8 >> re)) % 2) == 0) : 1'b0;
  endfunction

  function automatic void push(input logic o, input logic a, input string t);
    eO.push_back(o);
    eA.push_back(a);
    eT.push_back(t);
  endfunction

  // monitor: pops one expected sample per cycle
  initial begin
    logic o, a;
    string t;
    forever begin
      @(negedge clk);
      if (eO.size() > 0) begin
        o = eO.pop_front();
        a = eA.pop_front();
        t = eT.pop_front();
        chk(t, "codedOut", codedOut, o);
        chk("R4 R12", "bitAck", bitAck, a);
      end
    end
  end

  // data source: advances after each acknowledged bit
  initial begin
    logic a;
    forever begin
      @(posedge clk);
      a = bitAck;
      #1;
      if (feedOn && a) begin
        idx++;
        dataIn    = (idx < nBits) ? fbits[idx] : 1'b0;
        frameStop = (idx >= nBits);
      end
    end
  end

  task automatic runFrame(input logic m, input logic [1:0] r, input logic ro,
                          input int n, input logic [31:0] bits, input logic scr);
    int re, bl;
    logic mil, pas, prev;
    string base, tD;
    re  = (r == 2'b11) ? 2 : int'(r);
    bl  = 128 >> re;
    mil = (re == 0) && (m || ro);
    pas = !m && !ro;
    base = scr ? "R2 R3 R6 " : "R3 R6 ";
    @(negedge clk);
    activeMode = m; rateSel = r; initiatorRole = ro;
    for (int i = 0; i < n; i++) fbits[i] = bits[i];
    nBits = n; idx = 0;
    dataIn = (n > 0) ? bits[0] : 1'b0;
    frameStop = (n == 0);
    frameStart = 1'b1;
    feedOn = 1'b1;
    @(posedge clk);
    tD = mil ? "R8" : (pas ? "R11" : "R10");
    for (int c = 0; c < bl; c++)
      push(model(mil, pas, re, 0, 1'b0, 1'b0, c), (c == bl-1) && (n > 0), {base, tD});
    prev = 1'b0;
    for (int i = 0; i < n; i++) begin
      tD = mil ? (bits[i] ? "R7" : "R8") : (pas ? "R11" : "R10");
      for (int c = 0; c < bl; c++)
        push(model(mil, pas, re, 1, bits[i], prev, c), (c == bl-1) && (i < n-1), {base, tD});
      prev = bits[i];
    end
    tD = mil ? "R5 R9" : "R5 R10";
    for (int c = 0; c < bl; c++) push(model(mil, pas, re, 2, 1'b0, prev, c), 1'b0, {base, tD});
    if (mil)
      for (int c = 0; c < bl; c++) push(1'b1, 1'b0, {base, tD});
    for (int k = 0; k < 4; k++) push(1'b1, 1'b0, "R1");
    #1 frameStart = 1'b0;
    if (scr) begin
      repeat (6) @(posedge clk);
      #1;
      activeMode = ~m; initiatorRole = ~ro; rateSel = r ^ 2'b01;
      frameStart = 1'b1;
      @(posedge clk);
      #1 frameStart = 1'b0;
    end
    while (eO.size() > 0) @(negedge clk);
    feedOn = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "codedOut after reset", codedOut, 1'b1);
    chk("R1", "bitAck after reset", bitAck, 1'b0);
    // pause coding, initiator active: 1 0 0 1 1 0
    runFrame(1'b1, 2'b00, 1'b1, 6, 32'b011001, 1'b0);
    // pause coding, active target: 0 1 (end field after a 1)
    runFrame(1'b1, 2'b00, 1'b0, 2, 32'b10, 1'b0);
    // pause coding, empty frame
    runFrame(1'b0, 2'b00, 1'b1, 0, 32'b0, 1'b0);
    // Manchester initiator at 212
    runFrame(1'b1, 2'b01, 1'b1, 4, 32'b1101, 1'b0);
    // rate code 11 acts as 424, active target
    runFrame(1'b1, 2'b11, 1'b0, 3, 32'b010, 1'b0);
    // passive target at 106: Manchester plus subcarrier
    runFrame(1'b0, 2'b00, 1'b0, 3, 32'b110, 1'b0);
    // passive target at 212
    runFrame(1'b0, 2'b01, 1'b0, 2, 32'b01, 1'b0);
    // passive target at 424, settings and start request changed mid-frame
    runFrame(1'b0, 2'b10, 1'b0, 2, 32'b01, 1'b1);
    // pause coding with mid-frame changes
    runFrame(1'b1, 2'b00, 1'b1, 3, 32'b101, 1'b1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule